// File: doc/BRIEF.md
# Flag-Steered Fused Instruction Pairer

This block sits between instruction decode and issue. Each decoded instruction carries two steering flags: one says the instruction opens a fused pair and the other says it closes one. The pairer reads only these two flags and never looks at the opcode to decide on fusion. An opening instruction is parked in a single holding slot. When its closing partner arrives, the block emits one combined operation. That operation carries both opcodes, the destination of the closing half and all four source register specifiers. The fused unit behind it can therefore read four operands, for example to compute (a*b)+(c*d). The partial result between the halves stays inside that unit and never reaches the register file.

Instructions with neither flag pass through in the same cycle and are not changed. Broken sequences do not block the stream. A closing half that has no partner, an instruction with both flags set, and an opening half that is followed by something other than a closing half are each issued on their own, and each sets a sticky error indication. Flush empties the holding slot at once. Downstream back-pressure stalls both the input and the holding slot.

Top module: `fusion_pairer`

## Requirements
- R1: An instruction with both flags low (inFirst=0, inSecond=0) is offered on the output in the same cycle. outFused=0, outOpA=inOpcode, outOpB=0, outDest=inDest, outSrcA=inSrcA, outSrcB=inSrcB, outSrcC=0, outSrcD=0.
- R2: An instruction with only inFirst=1, arriving while the slot is empty, is accepted into the holding slot (inReady=1 when outReady=1). outValid stays 0 until its partner or another instruction arrives.
- R3: While the slot is full, an instruction with only inSecond=1 produces one output with outFused=1. outOpA is the held opcode and outOpB the new opcode. outDest is the new destination. outSrcA and outSrcB come from the held half and outSrcC and outSrcD from the new half. The slot is then empty.
- R4: An instruction with only inSecond=1 while the slot is empty passes through as in R1, and errSeen becomes 1 after the transfer edge.
- R5: While the slot is full, a valid instruction that is not second-only causes the held instruction to be issued alone in the R1 layout, using its own fields. The new instruction is refused in that cycle (inReady=0), handled from the empty state on the next cycle, and errSeen becomes 1.
- R6: An instruction with both flags set, arriving while the slot is empty, passes through alone as in R1 and sets errSeen.
- R7: While flush=1, outValid=0 and inReady=0, and the holding slot is empty from the next cycle on. A closing half that arrives after a flush is treated as in R4.
- R8: While outReady=0, inReady=0 and a held instruction is kept. The output offered during the stall has the same fields it has once outReady returns to 1.
- R9: After reset outValid=0 and errSeen=0. errSeen stays 1 once set until the next reset.
- R10: Fusion depends only on the flags: an opcode that was fused when flagged passes through unchanged when it arrives unflagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the holding slot, blocks transfers this cycle |
| inValid | input | 1 | Input instruction valid |
| inReady | output | 1 | Input instruction accepted this cycle |
| inFirst | input | 1 | Steering flag: opens a fused pair |
| inSecond | input | 1 | Steering flag: closes a fused pair |
| inOpcode | input | OPW | Opcode |
| inDest | input | REGW | Destination register |
| inSrcA | input | REGW | First source register |
| inSrcB | input | REGW | Second source register |
| outValid | output | 1 | Output operation valid |
| outReady | input | 1 | Downstream accepts the output |
| outFused | output | 1 | Output is a combined pair |
| outOpA | output | OPW | Opcode of the single or opening instruction |
| outOpB | output | OPW | Opcode of the closing half, 0 when not fused |
| outDest | output | REGW | Destination register |
| outSrcA | output | REGW | Source a |
| outSrcB | output | REGW | Source b |
| outSrcC | output | REGW | Source c, 0 when not fused |
| outSrcD | output | REGW | Source d, 0 when not fused |
| errSeen | output | 1 | Sticky malformed-pairing indication |

## Verification
The bench targets the orphaned opening half, which must be issued alone while the new instruction waits. A design that swallowed either instruction, or fused with a non-closing instruction, would give a wrong opcode pairing or drop an instruction. The bench also feeds in an opening half while another is already held, so that a design which overwrote the slot is caught losing the first one. It checks orphan closers and instructions with both flags set, where a faulty design would leave errSeen low or try to fuse. It flushes a held half and then sends a closer, and it stalls a ready pair, which exposes a slot that leaks past a flush or one that shifts while downstream is stalled.

// File: rtl/fusion_pairer_pkg.sv
package fusion_pairer_pkg;

  typedef enum logic [1:0] {
    KIND_PASS  = 2'd0,
    KIND_FUSED = 2'd1,
    KIND_HELD  = 2'd2
  } outKind_e;

  typedef struct packed {
    logic     loadHold;
    outKind_e kind;
  } pairStrobe_t;

endpackage

// File: rtl/fusion_pairer_ctrl.sv
module fusion_pairer_ctrl
  import fusion_pairer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flush,
  input  logic        inValid,
  input  logic        inFirst,
  input  logic        inSecond,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output logic        holdValid,
  output logic        errSeen,
  output pairStrobe_t strobe
);

  logic firstOnly;
  logic secondOnly;
  logic bothFlags;
  logic clearHold;
  logic errSet;

  assign firstOnly  = inFirst && !inSecond;
  assign secondOnly = inSecond && !inFirst;
  assign bothFlags  = inFirst && inSecond;

  always_comb begin
    strobe.loadHold = 1'b0;
    strobe.kind     = KIND_PASS;
    clearHold       = 1'b0;
    errSet          = 1'b0;
    inReady         = 1'b0;
    outValid        = 1'b0;
    if (flush) begin
      clearHold = 1'b1;
    end else if (holdValid) begin
      if (inValid) begin
        outValid = 1'b1;
        if (secondOnly) begin
          strobe.kind = KIND_FUSED;
          inReady     = outReady;
          clearHold   = outReady;
        end else begin
          strobe.kind = KIND_HELD;
          clearHold   = outReady;
          errSet      = outReady;
        end
      end
    end else if (inValid) begin
      if (firstOnly) begin
        inReady         = outReady;
        strobe.loadHold = outReady;
      end else begin
        outValid    = 1'b1;
        strobe.kind = KIND_PASS;
        inReady     = outReady;
        errSet      = outReady && (secondOnly || bothFlags);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      errSeen   <= 1'b0;
    end else begin
      if (strobe.loadHold) holdValid <= 1'b1;
      else if (clearHold)  holdValid <= 1'b0;
      if (errSet) errSeen <= 1'b1;
    end
  end

  AST_INREADY_NEEDS_DOWNSTREAM: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |-> !inReady); // R8
  AST_FLUSH_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (!outValid && !inReady)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !holdValid); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errSeen |=> errSeen); // R9
  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (holdValid && !inValid) |-> !outValid); // R2
  AST_FUSED_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && strobe.kind == KIND_FUSED) |-> holdValid); // R3

endmodule

// File: rtl/fusion_pairer_datapath.sv
module fusion_pairer_datapath
  import fusion_pairer_pkg::*;
#(
  parameter int OPW  = 8,
  parameter int REGW = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  pairStrobe_t     strobe,
  input  logic [OPW-1:0]  inOpcode,
  input  logic [REGW-1:0] inDest,
  input  logic [REGW-1:0] inSrcA,
  input  logic [REGW-1:0] inSrcB,
  output logic            outFused,
  output logic [OPW-1:0]  outOpA,
  output logic [OPW-1:0]  outOpB,
  output logic [REGW-1:0] outDest,
  output logic [REGW-1:0] outSrcA,
  output logic [REGW-1:0] outSrcB,
  output logic [REGW-1:0] outSrcC,
  output logic [REGW-1:0] outSrcD
);

  localparam logic [OPW-1:0]  OP_NONE  = '0;
  localparam logic [REGW-1:0] REG_NONE = '0;

  logic [OPW-1:0]  holdOp;
  logic [REGW-1:0] holdDest;
  logic [REGW-1:0] holdSrcA;
  logic [REGW-1:0] holdSrcB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdOp   <= OP_NONE;
      holdDest <= REG_NONE;
      holdSrcA <= REG_NONE;
      holdSrcB <= REG_NONE;
    end else if (strobe.loadHold) begin
      holdOp   <= inOpcode;
      holdDest <= inDest;
      holdSrcA <= inSrcA;
      holdSrcB <= inSrcB;
    end
  end

  always_comb begin
    outFused = 1'b0;
    outOpA   = inOpcode;
    outOpB   = OP_NONE;
    outDest  = inDest;
    outSrcA  = inSrcA;
    outSrcB  = inSrcB;
    outSrcC  = REG_NONE;
    outSrcD  = REG_NONE;
    unique case (strobe.kind)
      KIND_FUSED: begin
        outFused = 1'b1;
        outOpA   = holdOp;
        outOpB   = inOpcode;
        outDest  = inDest;
        outSrcA  = holdSrcA;
        outSrcB  = holdSrcB;
        outSrcC  = inSrcA;
        outSrcD  = inSrcB;
      end
      KIND_HELD: begin
        outOpA  = holdOp;
        outDest = holdDest;
        outSrcA = holdSrcA;
        outSrcB = holdSrcB;
      end
      default: ;
    endcase
  end

  AST_LOAD_ONLY_IDLE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHold |-> strobe.kind == KIND_PASS); // R2

endmodule

// File: rtl/fusion_pairer.sv
module fusion_pairer
  import fusion_pairer_pkg::*;
#(
  parameter int OPW  = 8,
  parameter int REGW = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            flush,
  input  logic            inValid,
  output logic            inReady,
  input  logic            inFirst,
  input  logic            inSecond,
  input  logic [OPW-1:0]  inOpcode,
  input  logic [REGW-1:0] inDest,
  input  logic [REGW-1:0] inSrcA,
  input  logic [REGW-1:0] inSrcB,
  output logic            outValid,
  input  logic            outReady,
  output logic            outFused,
  output logic [OPW-1:0]  outOpA,
  output logic [OPW-1:0]  outOpB,
  output logic [REGW-1:0] outDest,
  output logic [REGW-1:0] outSrcA,
  output logic [REGW-1:0] outSrcB,
  output logic [REGW-1:0] outSrcC,
  output logic [REGW-1:0] outSrcD,
  output logic            errSeen
);

  pairStrobe_t strobe;
  logic        holdValid;

  fusion_pairer_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .inValid  (inValid),
    .inFirst  (inFirst),
    .inSecond (inSecond),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .holdValid(holdValid),
    .errSeen  (errSeen),
    .strobe   (strobe)
  );

  fusion_pairer_datapath #(.OPW(OPW), .REGW(REGW)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inOpcode(inOpcode),
    .inDest  (inDest),
    .inSrcA  (inSrcA),
    .inSrcB  (inSrcB),
    .outFused(outFused),
    .outOpA  (outOpA),
    .outOpB  (outOpB),
    .outDest (outDest),
    .outSrcA (outSrcA),
    .outSrcB (outSrcB),
    .outSrcC (outSrcC),
    .outSrcD (outSrcD)
  );

  AST_STALL_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (holdValid && !outReady && !flush) |=> holdValid); // R8
  AST_UNFUSED_ZERO_CD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outFused) |-> (outSrcC == '0 && outSrcD == '0 && outOpB == '0)); // R1

endmodule

// File: tb/fusion_pairer_tb.sv
module fusion_pairer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int OPW  = 8;
  localparam int REGW = 5;

  logic clk = 1'b0;
  logic rstN, flush, inValid, inReady, inFirst, inSecond, outValid, outReady;
  logic outFused, errSeen;
  logic [OPW-1:0]  inOpcode, outOpA, outOpB;
  logic [REGW-1:0] inDest, inSrcA, inSrcB, outDest, outSrcA, outSrcB, outSrcC, outSrcD;

  int testsRun  = 0;
  int testsFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fusion_pairer #(.OPW(OPW), .REGW(REGW)) dut_i (.*);

  typedef struct packed {
    logic v, f, s;
    logic [7:0] op;
    logic [4:0] d, a, b;
    logic eov, efu;
    logic [7:0] eopA, eopB;
    logic [4:0] ed, ea, eb, ec, edd;
    logic eir, eer;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{0,0,0,8'h00,0,0,0,  0,0,8'h00,8'h00,0,0,0,0,0, 0,0, 4'd9},  // R9 idle
    '{1,0,0,8'h10,3,1,2,  1,0,8'h10,8'h00,3,1,2,0,0, 1,0, 4'd1},  // R1 plain
    '{1,1,0,8'h21,4,5,6,  0,0,8'h00,8'h00,0,0,0,0,0, 1,0, 4'd2},  // R2 opener held
    '{0,0,0,8'h00,0,0,0,  0,0,8'h00,8'h00,0,0,0,0,0, 0,0, 4'd2},  // R2 waiting
    '{1,0,1,8'h22,7,8,9,  1,1,8'h21,8'h22,7,5,6,8,9, 1,0, 4'd3},  // R3 fused
    '{1,0,0,8'h21,1,2,3,  1,0,8'h21,8'h00,1,2,3,0,0, 1,0, 4'd10}, // R10 same op unflagged
    '{1,0,1,8'h30,10,11,12, 1,0,8'h30,8'h00,10,11,12,0,0, 1,0, 4'd4}, // R4 orphan closer
    '{0,0,0,8'h00,0,0,0,  0,0,8'h00,8'h00,0,0,0,0,0, 0,1, 4'd4},  // R4 err now set
    '{1,1,0,8'h40,2,3,4,  0,0,8'h00,8'h00,0,0,0,0,0, 1,1, 4'd2},  // R2 opener
    '{1,0,0,8'h41,5,6,7,  1,0,8'h40,8'h00,2,3,4,0,0, 0,1, 4'd5},  // R5 held alone
    '{1,0,0,8'h41,5,6,7,  1,0,8'h41,8'h00,5,6,7,0,0, 1,1, 4'd5},  // R5 then passes
    '{1,1,0,8'h50,1,1,1,  0,0,8'h00,8'h00,0,0,0,0,0, 1,1, 4'd2},  // R2 opener
    '{1,1,0,8'h51,2,2,2,  1,0,8'h50,8'h00,1,1,1,0,0, 0,1, 4'd5},  // R5 opener on opener
    '{1,1,0,8'h51,2,2,2,  0,0,8'h00,8'h00,0,0,0,0,0, 1,1, 4'd2},  // R2 second opener held
    '{1,0,1,8'h52,3,4,5,  1,1,8'h51,8'h52,3,2,2,4,5, 1,1, 4'd3},  // R3 fused
    '{1,1,1,8'h60,6,7,8,  1,0,8'h60,8'h00,6,7,8,0,0, 1,1, 4'd6}   // R6 both flags
  };

  task automatic cmp(string tag, int act, int exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic v, logic f, logic s, logic [7:0] op, logic [4:0] d, logic [4:0] a, logic [4:0] b);
    @(negedge clk);
    inValid = v; inFirst = f; inSecond = s; inOpcode = op; inDest = d; inSrcA = a; inSrcB = b;
    #2;
  endtask

  task automatic checkOut(string tag, logic efu, logic [7:0] eopA, logic [7:0] eopB,
                          logic [4:0] ed, logic [4:0] ea, logic [4:0] eb, logic [4:0] ec, logic [4:0] edd);
    cmp({tag, " outValid"}, outValid, 1);
    cmp({tag, " outFused"}, outFused, efu);
    cmp({tag, " ops"}, {outOpA, outOpB}, {eopA, eopB});
    cmp({tag, " regs"}, {outDest, outSrcA, outSrcB, outSrcC, outSrcD}, {ed, ea, eb, ec, edd});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; flush = 1'b0; outReady = 1'b1;
    inValid = 0; inFirst = 0; inSecond = 0; inOpcode = 0; inDest = 0; inSrcA = 0; inSrcB = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    testsFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    doReset();
    #2;
    cmp("R9 reset outValid", outValid, 0);
    cmp("R9 reset errSeen", errSeen, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("vec%0d req R%0d", i, VECS[i].req);
      drive(VECS[i].v, VECS[i].f, VECS[i].s, VECS[i].op, VECS[i].d, VECS[i].a, VECS[i].b);
      cmp({tag, " outValid"}, outValid, VECS[i].eov);
      cmp({tag, " inReady"}, inReady, VECS[i].eir);
      cmp({tag, " errSeen"}, errSeen, VECS[i].eer);
      if (VECS[i].eov)
        checkOut(tag, VECS[i].efu, VECS[i].eopA, VECS[i].eopB, VECS[i].ed,
                 VECS[i].ea, VECS[i].eb, VECS[i].ec, VECS[i].edd);
    end

    // R9: sticky error survives many idle cycles, cleared by reset
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    cmp("R9 sticky", errSeen, 1);
    doReset();
    #2;
    cmp("R9 cleared by reset", errSeen, 0);

    // R6: both flags from a clean state set the error
    drive(1, 1, 1, 8'h61, 9, 1, 2);
    checkOut("R6 both flags pass", 0, 8'h61, 8'h00, 9, 1, 2, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    cmp("R6 err set", errSeen, 1);

    // R4: orphan closer from a clean state
    doReset();
    drive(1, 0, 1, 8'h33, 4, 5, 6);
    checkOut("R4 orphan pass", 0, 8'h33, 8'h00, 4, 5, 6, 0, 0);
    cmp("R4 orphan accepted", inReady, 1);
    drive(0, 0, 0, 0, 0, 0, 0);
    cmp("R4 err set", errSeen, 1);

    // R7: flush drops a held opener, following closer is an orphan
    doReset();
    drive(1, 1, 0, 8'h70, 1, 2, 3);
    cmp("R7 opener accepted", inReady, 1);
    @(negedge clk);
    flush = 1'b1;
    inValid = 1; inFirst = 0; inSecond = 1; inOpcode = 8'h71; inDest = 4; inSrcA = 5; inSrcB = 6;
    #2;
    cmp("R7 flush outValid", outValid, 0);
    cmp("R7 flush inReady", inReady, 0);
    @(negedge clk);
    flush = 1'b0;
    #2;
    checkOut("R7 closer after flush", 0, 8'h71, 8'h00, 4, 5, 6, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    cmp("R7 orphan error", errSeen, 1);

    // R8: stalled pair holds still, then issues as fused
    doReset();
    drive(1, 1, 0, 8'h80, 7, 8, 9);
    @(negedge clk);
    outReady = 1'b0;
    inValid = 1; inFirst = 0; inSecond = 1; inOpcode = 8'h81; inDest = 10; inSrcA = 11; inSrcB = 12;
    #2;
    cmp("R8 stall inReady", inReady, 0);
    checkOut("R8 stall offer", 1, 8'h80, 8'h81, 10, 8, 9, 11, 12);
    repeat (3) @(negedge clk);
    #2;
    cmp("R8 stall inReady later", inReady, 0);
    checkOut("R8 stall offer later", 1, 8'h80, 8'h81, 10, 8, 9, 11, 12);
    @(negedge clk);
    outReady = 1'b1;
    #2;
    cmp("R8 release inReady", inReady, 1);
    checkOut("R8 release fused", 1, 8'h80, 8'h81, 10, 8, 9, 11, 12);
    drive(0, 0, 0, 0, 0, 0, 0);
    cmp("R8 slot empty", outValid, 0);
    drive(1, 0, 0, 8'h90, 1, 1, 1);
    checkOut("R8 then plain", 0, 8'h90, 8'h00, 1, 1, 1, 0, 0);
    cmp("R3 no error on good pair", errSeen, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule